// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Timer

This block raises a periodic interrupt request from a slow oscillator clock. The oscillator is modelled as a clock-enable strobe (`osc_en`) inside the system clock domain. Each enabled cycle advances a binary prescaler. The prescaler first divides by a fixed power of two (1024 by default). A further power of two comes from a 3-bit prescale field. The prescaler output steps a 4-bit modulus counter. When the modulus counter completes its last step, a sticky timeout flag is set and the next period starts on the following enabled cycle.

Software loads one control byte through a simple write strobe. Bits [6:4] select the prescale and bits [3:0] hold the modulus. Every write restarts the period from zero. The flag is cleared by pulsing `flag_clr`. An interrupt request is produced while the flag is set and interrupts are enabled.

Three low-power inputs can freeze counting:
- Full stop always freezes it.
- Pseudo-stop freezes it unless a keep-running bit is set.
- Wait freezes it only when a stop-in-wait bit is set.

Top module: `rti_timer`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the control byte is 0x00, `tmo_flag` is 0 and `irq` is 0. With no write after reset, the flag stays 0.
- R2: Let p = control bits [6:4] with p from 1 to 7, and let m = control bits [3:0]. The flag rises after exactly 2^(DIV_LOG2-1+p) × (m+1) counting cycles following the control write.
- R3: Once a period ends, the next period begins on the very next counting cycle. The second timeout therefore falls exactly one period after the first, with no dead cycle.
- R4: Any control write resets both counters. The period is measured again from the write edge, whatever count had built up before it.
- R5: When control bits [6:4] are 000, the timer does not count and the flag never sets.
- R6: A clock edge with `osc_en` low is not a counting cycle.
- R7: While `stop_mode` is high, counting is frozen. While `pstop_mode` is high, counting is frozen unless `keep_in_pstop` is high.
- R8: While `wait_mode` is high, counting is frozen if `stop_in_wait` is high. If `stop_in_wait` is low, counting continues in wait mode.
- R9: The flag holds at 1 until an edge with `flag_clr` high clears it. If a clear and a timeout occur at the same edge, the flag is set.
- R10: `irq` is a register. After each edge it equals `irq_en` sampled at that edge AND the flag value that takes effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_en | input | 1 | Oscillator clock-enable strobe |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: [6:4] prescale select, [3:0] modulus, [7] unused |
| flag_clr | input | 1 | Clear the timeout flag |
| irq_en | input | 1 | Interrupt enable |
| stop_mode | input | 1 | Full stop mode active |
| pstop_mode | input | 1 | Pseudo-stop mode active |
| keep_in_pstop | input | 1 | Keep counting in pseudo-stop |
| wait_mode | input | 1 | Wait mode active |
| stop_in_wait | input | 1 | Freeze counting in wait mode |
| tmo_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
A counter that is off by one step, or a prescaler tap taken from the wrong bit, shifts the rise of `tmo_flag` by a countable number of edges. This shows up as soon as the first period ends. The bench therefore counts edges from the write to the rise and compares that count against the arithmetic period. It also measures the second period, which exposes any dead cycle between periods. A gate that leaks or sticks adds or removes exactly the number of frozen cycles from the measured period. A wrong set/clear priority shows up at the single edge where a held clear meets a timeout.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int PRE_W = 3;
  localparam int MOD_W = 4;
  localparam int CTL_W = 8;

  typedef struct packed {
    logic             spare;
    logic [PRE_W-1:0] pre;
    logic [MOD_W-1:0] modv;
  } rti_ctl_t;
endpackage

// File: rtl/rti_gate.sv
module rti_gate (
  input  logic osc_en,
  input  logic pre_on,
  input  logic stop_mode,
  input  logic pstop_mode,
  input  logic keep_in_pstop,
  input  logic wait_mode,
  input  logic stop_in_wait,
  output logic cnt_en
);
  logic frozen;

  always_comb begin
    frozen = stop_mode
           | (pstop_mode & ~keep_in_pstop)
           | (wait_mode & stop_in_wait);
    cnt_en = osc_en & pre_on & ~frozen;
  end
endmodule

// File: rtl/rti_prescaler.sv
module rti_prescaler
  import rti_pkg::*;
#(
  parameter int DIV_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             restart,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = DIV_LOG2 + (1 << PRE_W) - 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic             sel_on;

  // Bit i belongs to the tap when i < DIV_LOG2-1+sel
  always_comb begin
    sel_on = (sel != '0);
    mask   = '0;
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = sel_on && (i < (DIV_LOG2 - 1 + int'(sel)));
    end
    tick = cnt_en && !restart && sel_on && ((cnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !sel_on) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt + 1'b1;
    end
  end

  // A cycle that is not a counting cycle leaves the prescaler untouched
  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !restart && sel_on) |=> $stable(cnt));

  // A zero prescale field keeps the counter at zero
  assert_off_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (!sel_on && !restart) |=> (cnt == '0));
endmodule

// File: rtl/rti_modulus.sv
module rti_modulus
  import rti_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic [MOD_W-1:0] limit,
  output logic             timeout
);
  logic [MOD_W-1:0] cnt;

  always_comb timeout = step && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (timeout) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

  // The counter never runs past the programmed modulus
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt <= limit));

  // After a restart the modulus counter starts at zero
  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
endmodule

// File: rtl/rti_timer.sv
module rti_timer
  import rti_pkg::*;
#(
  parameter int DIV_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_en,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             flag_clr,
  input  logic             irq_en,
  input  logic             stop_mode,
  input  logic             pstop_mode,
  input  logic             keep_in_pstop,
  input  logic             wait_mode,
  input  logic             stop_in_wait,
  output logic             tmo_flag,
  output logic             irq
);
  rti_ctl_t ctl;
  logic     cnt_en;
  logic     pre_tick;
  logic     timeout;
  logic     flag_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (ctl_we) begin
      ctl <= rti_ctl_t'(ctl_wdata);
    end
  end

  rti_gate u_gate (
    .osc_en        (osc_en),
    .pre_on        (ctl.pre != '0),
    .stop_mode     (stop_mode),
    .pstop_mode    (pstop_mode),
    .keep_in_pstop (keep_in_pstop),
    .wait_mode     (wait_mode),
    .stop_in_wait  (stop_in_wait),
    .cnt_en        (cnt_en)
  );

  rti_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .restart (ctl_we),
    .sel     (ctl.pre),
    .tick    (pre_tick)
  );

  rti_modulus u_mod (
    .clk     (clk),
    .rst     (rst),
    .restart (ctl_we),
    .step    (pre_tick),
    .limit   (ctl.modv),
    .timeout (timeout)
  );

  // A timeout has priority over a clear
  always_comb begin
    if (timeout)       flag_nxt = 1'b1;
    else if (flag_clr) flag_nxt = 1'b0;
    else               flag_nxt = tmo_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      tmo_flag <= flag_nxt;
      irq      <= irq_en & flag_nxt;
    end
  end

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (tmo_flag && !flag_clr) |=> tmo_flag);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    timeout |=> tmo_flag);

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == ($past(irq_en) && tmo_flag)));

  assert_no_flag_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl.pre == '0 && !tmo_flag) |=> !tmo_flag);
endmodule

// File: tb/sim_rti_timer.sv
module sim_rti_timer;
  localparam int DL = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_en = 1'b1;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       flag_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic       stop_mode = 1'b0;
  logic       pstop_mode = 1'b0;
  logic       keep_in_pstop = 1'b0;
  logic       wait_mode = 1'b0;
  logic       stop_in_wait = 1'b0;
  logic       tmo_flag;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rti_timer #(.DIV_LOG2(DL)) u0 (
    .clk(clk), .rst(rst), .osc_en(osc_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .flag_clr(flag_clr), .irq_en(irq_en),
    .stop_mode(stop_mode), .pstop_mode(pstop_mode),
    .keep_in_pstop(keep_in_pstop), .wait_mode(wait_mode),
    .stop_in_wait(stop_in_wait), .tmo_flag(tmo_flag), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period(input int p, input int m);
    return (1 << (DL - 1 + p)) * (m + 1);
  endfunction

  // Write the control byte and clear the flag at the same edge
  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v; flag_clr = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; flag_clr = 1'b0;
  endtask

  // Count edges until the flag rises; returns the count
  task automatic wait_rise(input int limit, output int n);
    n = 0;
    while (n < limit && !tmo_flag) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_period(input int p, input int m);
    int n;
    int n2;
    int exp;
    exp = period(p, m);
    do_write({1'b0, 3'(p), 4'(m)});
    wait_rise(2 * exp + 20, n);
    check(n == exp, "R2 first period", n, exp);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    n2 = 1;
    wait_rise(2 * exp + 20, n);
    n2 = n2 + n;
    check(n2 == exp, "R3 back-to-back period", n2, exp);
  endtask

  // Freeze for 10 edges after the write via the chosen gate, then release
  task automatic gated_run(input int kind, input bit frozen, input string req);
    int n;
    int exp;
    exp = period(3, 1) + (frozen ? 10 : 0);
    case (kind)
      0: osc_en = 1'b0;
      1: stop_mode = 1'b1;
      2: begin pstop_mode = 1'b1; keep_in_pstop = 1'b0; end
      3: begin pstop_mode = 1'b1; keep_in_pstop = 1'b1; end
      4: begin wait_mode = 1'b1; stop_in_wait = 1'b1; end
      default: begin wait_mode = 1'b1; stop_in_wait = 1'b0; end
    endcase
    do_write(8'h31);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      n++;
    end
    osc_en = 1'b1; stop_mode = 1'b0; pstop_mode = 1'b0;
    keep_in_pstop = 1'b0; wait_mode = 1'b0; stop_in_wait = 1'b0;
    if (tmo_flag) begin
      check(exp <= 10, req, n, exp);
    end else begin
      int k;
      wait_rise(2 * exp + 20, k);
      n = n + k;
      check(n == exp, req, n, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tmo_flag == 1'b0, "R1 flag after reset", int'(tmo_flag), 0);
    check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    repeat (200) @(negedge clk);
    check(tmo_flag == 1'b0, "R1 idle control keeps flag low", int'(tmo_flag), 0);

    // R2 and R3 sweep
    for (int m = 0; m < 16; m++) run_period(1, m);
    for (int p = 2; p < 8; p++) begin
      run_period(p, 0);
      run_period(p, 3);
      run_period(p, 15);
    end

    // R5: prescale 000 disables
    do_write(8'h05);
    repeat (400) @(negedge clk);
    check(tmo_flag == 1'b0, "R5 disabled timer", int'(tmo_flag), 0);

    // R4: a write mid-period restarts
    do_write(8'h21);
    repeat (10) @(negedge clk);
    do_write(8'h21);
    wait_rise(100, n);
    check(n == period(2, 1), "R4 restart on write", n, period(2, 1));

    // R6..R8: gating
    gated_run(0, 1'b1, "R6 osc_en low not counted");
    gated_run(1, 1'b1, "R7 stop freezes");
    gated_run(2, 1'b1, "R7 pseudo-stop freezes");
    gated_run(3, 1'b0, "R7 pseudo-stop keep running");
    gated_run(4, 1'b1, "R8 wait freezes");
    gated_run(5, 1'b0, "R8 wait keeps counting");

    // R9: clear held through a timeout, set wins
    do_write(8'h10);
    flag_clr = 1'b1;
    repeat (period(1, 0)) @(negedge clk);
    check(tmo_flag == 1'b1, "R9 set wins over clear", int'(tmo_flag), 1);
    @(negedge clk);
    check(tmo_flag == 1'b0, "R9 clear drops flag", int'(tmo_flag), 0);
    flag_clr = 1'b0;
    repeat (period(1, 0) - 1) @(negedge clk);
    check(tmo_flag == 1'b1, "R9 flag set again", int'(tmo_flag), 1);
    repeat (20) @(negedge clk);
    check(tmo_flag == 1'b1, "R9 flag sticky", int'(tmo_flag), 1);

    // R10: irq gating
    check(irq == 1'b0, "R10 irq off while disabled", int'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R10 irq follows enable", int'(irq), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check(irq == 1'b0, "R10 irq drops with flag", int'(irq), 0);
    do_write(8'h12);
    wait_rise(100, n);
    check(irq == 1'b1, "R10 irq with new timeout", int'(irq), 1);
    irq_en = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R10 irq off after disable", int'(irq), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule